// File: doc/BRIEF.md
# Dual-Clock Queue with Handshake and Threshold Flags

This block is a first-in first-out buffer between two unrelated clock domains. A producer pushes words on its own clock and a consumer pops them on another clock. The store holds `2^ADDR_W` words. Each side has its own level flags and its own per-operation result flags.

The write side reports `full` and a `near_full` warning. One cycle after each push request it also reports whether the push was taken (`wr_ack`) or refused (`overflow`). The read side reports `empty` and a `near_empty` warning. One cycle after each pop request it reports `valid` with the word on `rd_data`, or `underflow`. A single active-low reset clears both sides. Each side releases that reset through its own synchroniser.

Pointers are one bit wider than the address and cross between the domains in Gray code through two-stage synchronisers. Each side derives its flags from its own pointer and the synchronised pointer of the other side. A flag can therefore lag the true level by a few cycles of the other clock, but always in the safe direction. The states of each side are the level classes the flags decode: for the write side, open, nearly full and full; for the read side, empty, nearly empty and filled. A side moves between them when its own pointer advances or when the synchronised pointer of the other side arrives.

Top module: `xclk_queue`

## Requirements
- R1: While reset is applied and after it is released with no traffic, `empty`=1, `near_empty`=1, `full`=0, `near_full`=0, `wr_ack`=0, `overflow`=0, `valid`=0, `underflow`=0 and `rd_data`=0.
- R2: A push request sampled while `full`=0 stores `wr_data` and raises `wr_ack` for exactly the next write-clock cycle, with `overflow`=0.
- R3: A push request sampled while `full`=1 raises `overflow` for the next write-clock cycle, with `wr_ack`=0, and leaves every stored word and their order unchanged.
- R4: A pop request sampled while `empty`=0 raises `valid` for the next read-clock cycle and presents the oldest stored word on `rd_data`, so that words leave in the order they were pushed.
- R5: A pop request sampled while `empty`=1 raises `underflow` for the next read-clock cycle, with `valid`=0, and `rd_data` keeps its previous value.
- R6: `full` is 1 when the write side sees `2^ADDR_W` words stored, and then `near_full` is also 1.
- R7: `empty` is 1 when the read side sees no word stored, and then `near_empty` is also 1.
- R8: `near_full` is 1 exactly when the write side sees no more than `THRESH` free slots.
- R9: `near_empty` is 1 exactly when the read side sees no more than `THRESH` stored words.
- R10: When pushes and pops run at the same time on the two unrelated clocks, every accepted word is delivered exactly once and in order.
- R11: `rd_data` changes only in a cycle where `valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low reset for both sides |
| wr_clk | input | 1 | Write-side clock, rising edge |
| wr_en | input | 1 | Push request |
| wr_data | input | DATA_W | Word to push |
| full | output | 1 | No free slot as seen by the write side |
| near_full | output | 1 | At most THRESH free slots |
| wr_ack | output | 1 | Previous push request was taken |
| overflow | output | 1 | Previous push request was refused |
| rd_clk | input | 1 | Read-side clock, rising edge |
| rd_en | input | 1 | Pop request |
| rd_data | output | DATA_W | Word from the last accepted pop |
| empty | output | 1 | No stored word as seen by the read side |
| near_empty | output | 1 | At most THRESH stored words |
| valid | output | 1 | Previous pop request delivered a word |
| underflow | output | 1 | Previous pop request was refused |

## Verification
A push accepted on the write clock and a pop accepted on the read clock can land in the same instant. In that case a pointer is moving while its Gray copy is being sampled by the other domain. The bench provokes this by running a producer and a consumer concurrently at 20 ns and 26 ns periods. Each side gates its request only on its own flag. Every word returned with `valid` is compared against a queue of the words whose push was issued while `full` was low, and any loss, repeat or reordering is judged as a failure.

// File: rtl/xq_pkg.sv
package xq_pkg;

    localparam int GW = 32;

    function automatic logic [GW-1:0] bin_to_gray(input logic [GW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [GW-1:0] gray_to_bin(input logic [GW-1:0] g);
        logic [GW-1:0] b;
        b[GW-1] = g[GW-1];
        for (int i = GW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/xq_rst_sync.sv
module xq_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic srst_n
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], 1'b1};
        end
    end

    assign srst_n = chain[STAGES-1];
endmodule

// File: rtl/xq_sync.sv
module xq_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= '0;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/xq_store.sv
module xq_store #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rclk,
    input  logic              rrst_n,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) cells[waddr] <= wdata;
    end

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= cells[raddr];
        end
    end
endmodule

// File: rtl/xq_wr_side.sv
module xq_wr_side #(
    parameter int ADDR_W = 4,
    parameter int THRESH = 2,
    localparam int PW    = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PW-1:0]     rgray_s,
    output logic              full,
    output logic              near_full,
    output logic              wr_ack,
    output logic              overflow,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [PW-1:0]     wgray
);
    import xq_pkg::*;

    localparam logic [PW-1:0] DEPTH_P = PW'(1 << ADDR_W);
    localparam logic [PW-1:0] THR_P   = PW'(THRESH);

    typedef enum logic [1:0] {W_OPEN, W_NEAR, W_FULL} wlevel_t;

    logic [PW-1:0] wbin, wbin_nx, rbin_s, used, spare;
    logic          take;
    wlevel_t       level;

    assign rbin_s  = PW'(gray_to_bin(GW'(rgray_s)));
    assign used    = wbin - rbin_s;
    assign spare   = DEPTH_P - used;

    always_comb begin
        if (used == DEPTH_P)     level = W_FULL;
        else if (spare <= THR_P) level = W_NEAR;
        else                     level = W_OPEN;
    end

    always_comb begin
        unique case (level)
            W_FULL:  begin full = 1'b1; near_full = 1'b1; end
            W_NEAR:  begin full = 1'b0; near_full = 1'b1; end
            default: begin full = 1'b0; near_full = 1'b0; end
        endcase
    end

    assign take     = wr_en & ~full;
    assign wbin_nx  = wbin + PW'(1);
    assign mem_we   = take;
    assign mem_addr = wbin[ADDR_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wbin     <= '0;
            wgray    <= '0;
            wr_ack   <= 1'b0;
            overflow <= 1'b0;
        end else begin
            wr_ack   <= take;
            overflow <= wr_en & full;
            if (take) begin
                wbin  <= wbin_nx;
                wgray <= PW'(bin_to_gray(GW'(wbin_nx)));
            end
        end
    end
endmodule

// File: rtl/xq_rd_side.sv
module xq_rd_side #(
    parameter int ADDR_W = 4,
    parameter int THRESH = 2,
    localparam int PW    = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [PW-1:0]     wgray_s,
    output logic              empty,
    output logic              near_empty,
    output logic              valid,
    output logic              underflow,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [PW-1:0]     rgray
);
    import xq_pkg::*;

    localparam logic [PW-1:0] THR_P = PW'(THRESH);

    typedef enum logic [1:0] {R_EMPTY, R_NEAR, R_FILLED} rlevel_t;

    logic [PW-1:0] rbin, rbin_nx, wbin_s, held;
    logic          take;
    rlevel_t       level;

    assign wbin_s = PW'(gray_to_bin(GW'(wgray_s)));
    assign held   = wbin_s - rbin;

    always_comb begin
        if (held == '0)         level = R_EMPTY;
        else if (held <= THR_P) level = R_NEAR;
        else                    level = R_FILLED;
    end

    always_comb begin
        unique case (level)
            R_EMPTY: begin empty = 1'b1; near_empty = 1'b1; end
            R_NEAR:  begin empty = 1'b0; near_empty = 1'b1; end
            default: begin empty = 1'b0; near_empty = 1'b0; end
        endcase
    end

    assign take     = rd_en & ~empty;
    assign rbin_nx  = rbin + PW'(1);
    assign mem_re   = take;
    assign mem_addr = rbin[ADDR_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rbin      <= '0;
            rgray     <= '0;
            valid     <= 1'b0;
            underflow <= 1'b0;
        end else begin
            valid     <= take;
            underflow <= rd_en & empty;
            if (take) begin
                rbin  <= rbin_nx;
                rgray <= PW'(bin_to_gray(GW'(rbin_nx)));
            end
        end
    end
endmodule

// File: rtl/xclk_queue.sv
module xclk_queue #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4,
    parameter int THRESH = 2,
    parameter int SYNC_N = 2
) (
    input  logic              rst_n,
    input  logic              wr_clk,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full,
    output logic              near_full,
    output logic              wr_ack,
    output logic              overflow,
    input  logic              rd_clk,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic              near_empty,
    output logic              valid,
    output logic              underflow
);
    localparam int PW = ADDR_W + 1;

    logic              w_rst_n_s, r_rst_n_s;
    logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
    logic              mem_we, mem_re;
    logic [ADDR_W-1:0] waddr, raddr;

    xq_rst_sync #(.STAGES(SYNC_N)) u_wrst (
        .clk(wr_clk), .arst_n(rst_n), .srst_n(w_rst_n_s));
    xq_rst_sync #(.STAGES(SYNC_N)) u_rrst (
        .clk(rd_clk), .arst_n(rst_n), .srst_n(r_rst_n_s));

    xq_sync #(.W(PW), .STAGES(SYNC_N)) u_r2w (
        .clk(wr_clk), .rst_n(w_rst_n_s), .d(rgray), .q(rgray_s));
    xq_sync #(.W(PW), .STAGES(SYNC_N)) u_w2r (
        .clk(rd_clk), .rst_n(r_rst_n_s), .d(wgray), .q(wgray_s));

    xq_wr_side #(.ADDR_W(ADDR_W), .THRESH(THRESH)) u_wr (
        .clk(wr_clk), .rst_n(w_rst_n_s), .wr_en(wr_en), .rgray_s(rgray_s),
        .full(full), .near_full(near_full), .wr_ack(wr_ack), .overflow(overflow),
        .mem_we(mem_we), .mem_addr(waddr), .wgray(wgray));

    xq_rd_side #(.ADDR_W(ADDR_W), .THRESH(THRESH)) u_rd (
        .clk(rd_clk), .rst_n(r_rst_n_s), .rd_en(rd_en), .wgray_s(wgray_s),
        .empty(empty), .near_empty(near_empty), .valid(valid), .underflow(underflow),
        .mem_re(mem_re), .mem_addr(raddr), .rgray(rgray));

    xq_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .wclk(wr_clk), .we(mem_we), .waddr(waddr), .wdata(wr_data),
        .rclk(rd_clk), .rrst_n(r_rst_n_s), .re(mem_re), .raddr(raddr), .rdata(rd_data));
endmodule

// File: rtl/xclk_queue_chk.sv
module xclk_queue_chk #(
    parameter int DATA_W = 8
) (
    input logic              wr_clk,
    input logic              rd_clk,
    input logic              w_rst_n_s,
    input logic              r_rst_n_s,
    input logic              wr_en,
    input logic              full,
    input logic              near_full,
    input logic              wr_ack,
    input logic              overflow,
    input logic              rd_en,
    input logic              empty,
    input logic              near_empty,
    input logic              valid,
    input logic              underflow,
    input logic [DATA_W-1:0] rd_data
);
    a_r2_push_acked: assert property (@(posedge wr_clk) disable iff (!w_rst_n_s)
        (wr_en && !full) |=> (wr_ack && !overflow));

    a_r3_push_refused: assert property (@(posedge wr_clk) disable iff (!w_rst_n_s)
        (wr_en && full) |=> (overflow && !wr_ack));

    a_r4_pop_valid: assert property (@(posedge rd_clk) disable iff (!r_rst_n_s)
        (rd_en && !empty) |=> (valid && !underflow));

    a_r5_pop_refused: assert property (@(posedge rd_clk) disable iff (!r_rst_n_s)
        (rd_en && empty) |=> (underflow && !valid && $stable(rd_data)));

    a_r6_full_near: assert property (@(posedge wr_clk) disable iff (!w_rst_n_s)
        full |-> near_full);

    a_r7_empty_near: assert property (@(posedge rd_clk) disable iff (!r_rst_n_s)
        empty |-> near_empty);

    a_r11_data_moves_on_valid: assert property (@(posedge rd_clk) disable iff (!r_rst_n_s)
        !$stable(rd_data) |-> valid);
endmodule

bind xclk_queue xclk_queue_chk #(.DATA_W(DATA_W)) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk),
    .w_rst_n_s(w_rst_n_s), .r_rst_n_s(r_rst_n_s),
    .wr_en(wr_en), .full(full), .near_full(near_full),
    .wr_ack(wr_ack), .overflow(overflow),
    .rd_en(rd_en), .empty(empty), .near_empty(near_empty),
    .valid(valid), .underflow(underflow), .rd_data(rd_data));

// File: tb/xclk_queue_test.sv
module xclk_queue_test;
    localparam int DW    = 8;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;
    localparam int TH    = 2;

    logic          rst_n = 1'b0;
    logic          wr_clk = 1'b0, rd_clk = 1'b0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          full, near_full, wr_ack, overflow;
    logic [DW-1:0] rd_data;
    logic          empty, near_empty, valid, underflow;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [DW-1:0] model[$];

    always #10 wr_clk = ~wr_clk;
    always #13 rd_clk = ~rd_clk;

    xclk_queue #(.DATA_W(DW), .ADDR_W(AW), .THRESH(TH)) uut (
        .rst_n(rst_n), .wr_clk(wr_clk), .wr_en(wr_en), .wr_data(wr_data),
        .full(full), .near_full(near_full), .wr_ack(wr_ack), .overflow(overflow),
        .rd_clk(rd_clk), .rd_en(rd_en), .rd_data(rd_data), .empty(empty),
        .near_empty(near_empty), .valid(valid), .underflow(underflow));

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge rd_clk);
        repeat (6) @(negedge wr_clk);
    endtask

    task automatic push(input logic [DW-1:0] d, input bit ok);
        @(negedge wr_clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge wr_clk);
        wr_en = 1'b0;
        if (ok) begin
            model.push_back(d);
            check("R2", "wr_ack", int'(wr_ack), 1);
            check("R2", "overflow", int'(overflow), 0);
        end else begin
            check("R3", "overflow", int'(overflow), 1);
            check("R3", "wr_ack", int'(wr_ack), 0);
        end
    endtask

    task automatic pop(input bit ok, input logic [DW-1:0] prev);
        logic [DW-1:0] exp;
        @(negedge rd_clk);
        rd_en = 1'b1;
        @(negedge rd_clk);
        rd_en = 1'b0;
        if (ok) begin
            exp = model.pop_front();
            check("R4", "valid", int'(valid), 1);
            check("R4", "rd_data", int'(rd_data), int'(exp));
        end else begin
            check("R5", "underflow", int'(underflow), 1);
            check("R5", "valid", int'(valid), 0);
            check("R5", "rd_data held", int'(rd_data), int'(prev));
        end
    endtask

    task automatic t_reset();
        check("R1", "empty", int'(empty), 1);
        check("R1", "near_empty", int'(near_empty), 1);
        check("R1", "full", int'(full), 0);
        check("R1", "near_full", int'(near_full), 0);
        check("R1", "wr_ack", int'(wr_ack), 0);
        check("R1", "overflow", int'(overflow), 0);
        check("R1", "valid", int'(valid), 0);
        check("R1", "underflow", int'(underflow), 0);
        check("R1", "rd_data", int'(rd_data), 0);
    endtask

    task automatic t_underflow_empty();
        pop(1'b0, '0);
        check("R7", "empty stays", int'(empty), 1);
    endtask

    task automatic t_fill_and_overflow();
        for (int i = 0; i < DEPTH; i++) begin
            check("R8", "near_full before push", int'(near_full), int'((DEPTH - i) <= TH));
            check("R6", "full before push", int'(full), 0);
            push(8'h30 + 8'(i), 1'b1);
        end
        settle();
        check("R6", "full", int'(full), 1);
        check("R6", "near_full with full", int'(near_full), 1);
        push(8'hEE, 1'b0);
        check("R3", "still full", int'(full), 1);
        settle();
        check("R9", "near_empty when full", int'(near_empty), 0);
        check("R7", "empty when full", int'(empty), 0);
    endtask

    task automatic t_drain();
        logic [DW-1:0] last;
        for (int i = 0; i < DEPTH; i++) begin
            check("R9", "near_empty level", int'(near_empty), int'((DEPTH - i) <= TH));
            check("R7", "not empty", int'(empty), 0);
            last = model[0];
            pop(1'b1, '0);
        end
        check("R7", "empty after drain", int'(empty), 1);
        pop(1'b0, last);
        settle();
        check("R8", "near_full after drain", int'(near_full), 0);
    endtask

    task automatic t_stream();
        int n = 40;
        fork
            begin
                int sent = 0;
                while (sent < n) begin
                    @(negedge wr_clk);
                    if (!full) begin
                        wr_en = 1'b1; wr_data = 8'h80 + 8'(sent);
                        model.push_back(wr_data);
                        sent++;
                    end else begin
                        wr_en = 1'b0;
                    end
                end
                @(negedge wr_clk);
                wr_en = 1'b0;
            end
            begin
                int got = 0, asked = 0;
                logic [DW-1:0] exp;
                while (got < n) begin
                    @(negedge rd_clk);
                    if (valid) begin
                        exp = model.pop_front();
                        check("R10", "stream word", int'(rd_data), int'(exp));
                        got++;
                    end
                    if (!empty && asked < n) begin
                        rd_en = 1'b1; asked++;
                    end else begin
                        rd_en = 1'b0;
                    end
                end
                rd_en = 1'b0;
            end
        join
        settle();
        check("R10", "empty after stream", int'(empty), 1);
        check("R10", "model drained", model.size(), 0);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge wr_clk);
        t_reset();
        rst_n = 1'b1;
        settle();
        t_reset();
        t_underflow_empty();
        t_fill_and_overflow();
        t_drain();
        t_stream();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule